// File: doc/BRIEF.md
# Function Unit: Arithmetic, Logic and Shift Under One Select

This block is the compute core of a register-to-register datapath. It is purely combinational. It takes two operands, `a_i` and `b_i`, and a 4-bit operation code `fs_i`. In the same cycle it produces a result word and four condition flags. The flags are signed overflow, carry out, negative and zero.

Inside, an adder/logic stage and a one-position shifter both compute all the time. A small decoder turns the operation code into three things: the adder operand and carry-in, the shifter direction, and the output source.

- Codes 0000 to 0111 are arithmetic. They are built from one adder by choosing the second operand and the carry-in.
- Codes 1000 to 1011 are bitwise logic.
- Codes 1100 to 1110 move operand B unchanged, shifted right or shifted left.
- Code 1111 passes operand A through.

The output source is the shifter when both upper code bits are set, and the adder/logic stage otherwise. The one exception is code 1111, which selects operand A.

A surrounding datapath feeds the operands from register read ports and writes the result back on the next clock edge. The flags are sampled alongside the result.

Top module: `func_unit`

## Requirements
- R1: For codes 0000 to 0111 the result is, in code order, A, A+1, A+B, A+B+1, A+~B, A+~B+1, A-1 and A, modulo 2^WIDTH. Code 0110 adds all ones with no carry-in, and code 0111 adds all ones with a carry-in of 1.
- R2: For codes 0000 to 0111, `c_o` is bit WIDTH of the unsigned sum of A, the selected second operand and the carry-in.
- R3: For codes 0000 to 0111, `v_o` is 1 exactly when A and the selected second operand have equal MSBs and the result MSB differs from them.
- R4: Codes 1000, 1001, 1010 and 1011 give A AND B, A OR B, A XOR B and NOT A respectively.
- R5: Codes 1100, 1101 and 1110 give B, B shifted right by one with a 0 entering the MSB, and B shifted left by one with a 0 entering the LSB. Operand A has no effect on these codes.
- R6: Code 1111 gives A unchanged.
- R7: For codes 1000 to 1111, `c_o` and `v_o` are 0.
- R8: `n_o` equals the MSB of the result for every code.
- R9: `z_o` is 1 exactly when every bit of the result is 0, for every code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B, also the shifter source |
| fs_i | input | 4 | Operation code |
| f_o | output | WIDTH | Result word |
| v_o | output | 1 | Signed overflow flag |
| c_o | output | 1 | Carry-out flag |
| n_o | output | 1 | Negative flag (result MSB) |
| z_o | output | 1 | Zero flag |

## Verification
There is no stored state, so a wrong internal decode shows up at the ports in the same cycle the code is applied.

- A bad output-source decode routes the wrong stage to `f_o`. This is seen for any operand pair that makes the adder and shifter results differ.
- A wrong operand or carry-in choice shows as an off-by-one or sign error in `f_o`, or as a mismatched `c_o` or `v_o`, in that same cycle.
- Overflow and carry corners are reachable only with specific operand pairs. They are therefore driven on purpose: 7F+1, 80-1, and equal operands subtracted.

// File: rtl/func_unit_pkg.sv
`timescale 1ns/1ps
package func_unit_pkg;

  typedef enum logic [1:0] {
    SRC_ALU   = 2'd0,
    SRC_SHIFT = 2'd1,
    SRC_PASSA = 2'd2
  } fu_src_e;

  typedef enum logic [1:0] {
    SH_PASS  = 2'd0,
    SH_RIGHT = 2'd1,
    SH_LEFT  = 2'd2,
    SH_SPARE = 2'd3
  } fu_shift_e;

  localparam int unsigned FS_W = 4;

endpackage

// File: rtl/func_unit_decode.sv
`timescale 1ns/1ps
module func_unit_decode
  import func_unit_pkg::*;
(
  input  logic [FS_W-1:0] fs_i,
  output fu_src_e         src_o,
  output fu_shift_e       shift_op_o
);

  logic mf;
  assign mf = fs_i[3] & fs_i[2];

  always_comb begin
    if (!mf)              src_o = SRC_ALU;
    else if (&fs_i[1:0])  src_o = SRC_PASSA;  // code 1111
    else                  src_o = SRC_SHIFT;
  end

  assign shift_op_o = fu_shift_e'(fs_i[1:0]);

endmodule

// File: rtl/func_unit_alu.sv
`timescale 1ns/1ps
module func_unit_alu
  import func_unit_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [FS_W-1:0]  fs_i,
  output logic [WIDTH-1:0] g_o,
  output logic             carry_o,
  output logic             ovf_o
);

  localparam int unsigned SUM_W = WIDTH + 1;

  logic [WIDTH-1:0] opnd_y;
  logic [SUM_W-1:0] sum;
  logic [WIDTH-1:0] logic_res;

  // second adder operand: 0, B, ~B or all ones
  always_comb begin
    unique case (fs_i[2:1])
      2'b00:   opnd_y = '0;
      2'b01:   opnd_y = b_i;
      2'b10:   opnd_y = ~b_i;
      default: opnd_y = '1;
    endcase
  end

  assign sum = {1'b0, a_i} + {1'b0, opnd_y} + {{WIDTH{1'b0}}, fs_i[0]};

  always_comb begin
    unique case (fs_i[1:0])
      2'b00:   logic_res = a_i & b_i;
      2'b01:   logic_res = a_i | b_i;
      2'b10:   logic_res = a_i ^ b_i;
      default: logic_res = ~a_i;
    endcase
  end

  assign g_o     = fs_i[3] ? logic_res : sum[WIDTH-1:0];
  assign carry_o = ~fs_i[3] & sum[WIDTH];
  assign ovf_o   = ~fs_i[3] & (a_i[WIDTH-1] == opnd_y[WIDTH-1])
                            & (sum[WIDTH-1] != a_i[WIDTH-1]);

endmodule

// File: rtl/func_unit_shift.sv
`timescale 1ns/1ps
module func_unit_shift
  import func_unit_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] b_i,
  input  fu_shift_e        op_i,
  output logic [WIDTH-1:0] h_o
);

  always_comb begin
    unique case (op_i)
      SH_RIGHT: h_o = {1'b0, b_i[WIDTH-1:1]};
      SH_LEFT:  h_o = {b_i[WIDTH-2:0], 1'b0};
      default:  h_o = b_i;  // SH_PASS and unused SH_SPARE
    endcase
  end

endmodule

// File: rtl/func_unit.sv
`timescale 1ns/1ps
module func_unit
  import func_unit_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       fs_i,
  output logic [WIDTH-1:0] f_o,
  output logic             v_o,
  output logic             c_o,
  output logic             n_o,
  output logic             z_o
);

  fu_src_e          src;
  fu_shift_e        shift_op;
  logic [WIDTH-1:0] g_res;
  logic [WIDTH-1:0] h_res;
  logic             alu_c;
  logic             alu_v;

  func_unit_decode u_decode (
    .fs_i       (fs_i),
    .src_o      (src),
    .shift_op_o (shift_op)
  );

  func_unit_alu #(.WIDTH(WIDTH)) u_alu (
    .a_i     (a_i),
    .b_i     (b_i),
    .fs_i    (fs_i),
    .g_o     (g_res),
    .carry_o (alu_c),
    .ovf_o   (alu_v)
  );

  func_unit_shift #(.WIDTH(WIDTH)) u_shift (
    .b_i  (b_i),
    .op_i (shift_op),
    .h_o  (h_res)
  );

  always_comb begin
    unique case (src)
      SRC_SHIFT: f_o = h_res;
      SRC_PASSA: f_o = a_i;
      default:   f_o = g_res;
    endcase
  end

  // adder flags only reach the ports when the ALU result is selected
  assign c_o = (src == SRC_ALU) & alu_c;
  assign v_o = (src == SRC_ALU) & alu_v;
  assign n_o = f_o[WIDTH-1];
  assign z_o = ~|f_o;

  always_comb begin
    if (fs_i == 4'b0111) begin
      AST_INC_DEC_IDENT: assert (f_o == a_i && c_o) else $error("code 0111 not identity with carry"); // R1
    end
    if (fs_i == 4'b0010 && v_o) begin
      AST_ADD_OVF_SIGNS: assert (a_i[WIDTH-1] == b_i[WIDTH-1] && f_o[WIDTH-1] != a_i[WIDTH-1]) else $error("bad add overflow"); // R3
    end
    if (fs_i == 4'b1100) begin
      AST_XFER_B: assert (f_o == b_i) else $error("transfer B mismatch"); // R5
    end
    if (fs_i == 4'b1101) begin
      AST_SHR_FILL: assert (!f_o[WIDTH-1]) else $error("right shift fill not zero"); // R5
    end
    if (fs_i == 4'b1111) begin
      AST_PASS_A: assert (f_o == a_i) else $error("code 1111 not pass A"); // R6
    end
    if (fs_i[3]) begin
      AST_NO_FLAGS_NONARITH: assert (!c_o && !v_o) else $error("flags set on non-arith code"); // R7
    end
  end

endmodule

// File: tb/func_unit_tb_top.sv
`timescale 1ns/1ps
module func_unit_tb_top;

  localparam int W = 8;
  localparam int WATCHDOG_CYCLES = 100000;

  typedef struct packed {
    logic [3:0]   fs;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] f;
    logic         c;
    logic         v;
  } vec_t;

  localparam int NVEC = 24;
  localparam vec_t VECS [NVEC] = '{
    '{4'h0, 8'h5A, 8'h33, 8'h5A, 1'b0, 1'b0},
    '{4'h1, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b0},
    '{4'h1, 8'h7F, 8'h00, 8'h80, 1'b0, 1'b1},
    '{4'h2, 8'h70, 8'h70, 8'hE0, 1'b0, 1'b1},
    '{4'h2, 8'hF0, 8'h20, 8'h10, 1'b1, 1'b0},
    '{4'h3, 8'h01, 8'h02, 8'h04, 1'b0, 1'b0},
    '{4'h4, 8'h10, 8'h05, 8'h0A, 1'b1, 1'b0},
    '{4'h5, 8'h10, 8'h05, 8'h0B, 1'b1, 1'b0},
    '{4'h5, 8'h80, 8'h01, 8'h7F, 1'b1, 1'b1},
    '{4'h5, 8'h05, 8'h05, 8'h00, 1'b1, 1'b0},
    '{4'h6, 8'h00, 8'h00, 8'hFF, 1'b0, 1'b0},
    '{4'h6, 8'h80, 8'h00, 8'h7F, 1'b1, 1'b1},
    '{4'h7, 8'h3C, 8'h00, 8'h3C, 1'b1, 1'b0},
    '{4'h8, 8'hCC, 8'hAA, 8'h88, 1'b0, 1'b0},
    '{4'h9, 8'hCC, 8'hAA, 8'hEE, 1'b0, 1'b0},
    '{4'hA, 8'hCC, 8'hAA, 8'h66, 1'b0, 1'b0},
    '{4'hB, 8'hCC, 8'hAA, 8'h33, 1'b0, 1'b0},
    '{4'hB, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b0},
    '{4'hC, 8'hFF, 8'h81, 8'h81, 1'b0, 1'b0},
    '{4'hD, 8'hFF, 8'h81, 8'h40, 1'b0, 1'b0},
    '{4'hE, 8'hFF, 8'h81, 8'h02, 1'b0, 1'b0},
    '{4'hD, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0},
    '{4'hF, 8'h96, 8'h00, 8'h96, 1'b0, 1'b0},
    '{4'h8, 8'hF0, 8'h0F, 8'h00, 1'b0, 1'b0}
  };

  logic         clk = 1'b0;
  logic [W-1:0] a_s = '0;
  logic [W-1:0] b_s = '0;
  logic [3:0]   fs_s = '0;
  logic [W-1:0] f_s;
  logic         v_s, c_s, n_s, z_s;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  func_unit #(.WIDTH(W)) dut_i (
    .a_i  (a_s),
    .b_i  (b_s),
    .fs_i (fs_s),
    .f_o  (f_s),
    .v_o  (v_s),
    .c_o  (c_s),
    .n_o  (n_s),
    .z_o  (z_s)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s fs=%b a=%h b=%h actual=%h expected=%h", req, fs_s, a_s, b_s, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] fs, input logic [W-1:0] a, input logic [W-1:0] b);
    @(posedge clk);
    fs_s = fs; a_s = a; b_s = b;
    @(negedge clk);
  endtask

  // expected behaviour written from the requirements
  task automatic model(input logic [3:0] fs, input logic [W-1:0] a, input logic [W-1:0] b,
                       output logic [W-1:0] f, output logic c, output logic v);
    logic [W-1:0] y;
    logic [W:0]   s;
    c = 1'b0; v = 1'b0;
    if (!fs[3]) begin
      case (fs[2:1])
        2'b00: y = '0;
        2'b01: y = b;
        2'b10: y = ~b;
        default: y = '1;
      endcase
      s = {1'b0, a} + {1'b0, y} + W'(fs[0]);
      f = s[W-1:0];
      c = s[W];
      v = (a[W-1] == y[W-1]) && (f[W-1] != a[W-1]);
    end else begin
      case (fs)
        4'h8: f = a & b;
        4'h9: f = a | b;
        4'hA: f = a ^ b;
        4'hB: f = ~a;
        4'hC: f = b;
        4'hD: f = b >> 1;
        4'hE: f = b << 1;
        default: f = a;
      endcase
    end
  endtask

  function automatic string f_req(input logic [3:0] fs);
    if (!fs[3]) return "R1";
    if (fs < 4'hC) return "R4";
    if (fs == 4'hF) return "R6";
    return "R5";
  endfunction

  task automatic check_all(input logic [W-1:0] ef, input logic ec, input logic ev);
    check(f_req(fs_s), f_s, ef);
    check(fs_s[3] ? "R7" : "R2", W'(c_s), W'(ec));
    check(fs_s[3] ? "R7" : "R3", W'(v_s), W'(ev));
    check("R8", W'(n_s), W'(ef[W-1]));
    check("R9", W'(z_s), W'(ef == '0));
  endtask

  initial begin
    logic [W-1:0] ef;
    logic ec, ev;
    logic [W-1:0] f_first;

    // idle state: all-zero inputs give code 0000 result 0
    @(negedge clk);
    check("R1", f_s, '0);
    check("R9", W'(z_s), W'(1'b1));
    check("R2", W'(c_s), '0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].fs, VECS[i].a, VECS[i].b);
      check_all(VECS[i].f, VECS[i].c, VECS[i].v);
    end

    // R5: operand A has no effect on shift/transfer codes
    for (int code = 12; code < 15; code++) begin
      apply(4'(code), 8'h00, 8'hB5);
      f_first = f_s;
      apply(4'(code), 8'hFF, 8'hB5);
      check("R5", f_s, f_first);
    end

    // random sweep over every code
    for (int code = 0; code < 16; code++) begin
      for (int k = 0; k < 250; k++) begin
        logic [W-1:0] ra, rb;
        ra = W'($urandom);
        rb = W'($urandom);
        apply(4'(code), ra, rb);
        model(4'(code), ra, rb, ef, ec, ev);
        check_all(ef, ec, ev);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule